// File: doc/BRIEF.md
# Two-Wire Slave Byte Store

This block is a slave-only two-wire serial interface placed in front of a 256-byte storage array (2,048 bits). The serial clock and data lines are first brought into the system clock domain through two-flop synchronizers. START and STOP conditions are then recognised from how the data line moves while the clock is high. The block never drives the clock and never begins a transfer. Its only output is an open-drain style pull-down request for the data line.

After a START, the block shifts in a select byte, most significant bit first. It accepts the byte when the upper four bits are the family code 1010 and the next three bits equal its strap inputs. Eight instances with distinct straps can therefore share one bus. The last bit of the select byte chooses the direction (1 = read).

In a write transfer, the master sends a word address followed by data bytes. In a read transfer, the block returns bytes starting at the current address. Every accepted byte is acknowledged by pulling data low during the ninth clock. The internal address increments after each data byte and wraps from 255 to 0.

Top module: `twi_store_slave`

## Requirements
- R1: While reset is high and in the cycle after it, the data pull-down output is released (0), and the block is idle.
- R2: A falling data edge while the clock is high is a START. It aborts any partly received byte, which is then not stored, and the block waits for a select byte. A START is also accepted in the middle of a transfer (repeated START).
- R3: The select byte, sent MSB first, is accepted only when bits 7..4 are 1010 and bits 3..1 equal the strap inputs (bit 3 = strap[2]). An accepted select byte is acknowledged by pulling data low for the whole ninth clock pulse. Any other family code is not acknowledged.
- R4: After a select byte that does not match, the block pulls data low for no further byte and stores nothing until the next START.
- R5: In a write transfer, the byte after the select byte sets the word address. Each following byte is stored at the current address, then the address increments. Every byte is acknowledged.
- R6: The address increments modulo 256 (255 is followed by 0), for both writes and reads.
- R7: In a read transfer, the block drives the byte at the current address MSB first, one bit per clock pulse, then increments the address. It sends the next byte as long as the master acknowledges (data low on the ninth clock).
- R8: A not-acknowledge from the master (data high on the ninth clock) ends a read. After that the block releases the data line until the next START.
- R9: A rising data edge while the clock is high is a STOP. It returns the block to idle with the line released. Bytes that were completed before the STOP remain stored, and no byte clocked after the STOP without a START is acknowledged.
- R10: The pull-down output changes only while the synchronized clock is low, so the data line stays stable during every clock-high period.
- R11: Changing the strap inputs changes which select byte is accepted: the new value is acknowledged and the old value is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| dev_strap | input | 3 | Device address straps, compared against select bits 3..1 |
| sda_drive_low | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The bench aims at a repeated START in the middle of a byte. A design that committed the partial shift register would corrupt the addressed location, and the bench sees this when it reads that location back. It writes across the top of the address space and reads back with acknowledges. A design with a 9-bit or saturating pointer would return or store data at the wrong location instead of at address 0. It sends select bytes with a wrong family code, with wrong straps, and with no START after a STOP. A design that decoded too loosely would acknowledge one of them or store the bytes that follow. It checks that read data stays stable across each clock-high period and that the line is free after a master not-acknowledge. A design that updated its output on the wrong edge, or kept driving after the not-acknowledge, would produce false START or STOP conditions on the bus.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int unsigned WORD_ADDR_W = 8;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned STRAP_W     = 3;
    localparam logic [3:0]  FAMILY_CODE = 4'b1010;
    localparam int unsigned BIT_CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_WORD_ADDR,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } twi_state_e;

    typedef struct packed {
        logic scl_level;
        logic sda_level;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic select_hit(input logic [BYTE_W-1:0] sel,
                                        input logic [STRAP_W-1:0] strap);
        return (sel[BYTE_W-1 -: 4] == FAMILY_CODE) &&
               (sel[STRAP_W:1] == strap);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    // Synchronizer chains; the idle bus level is high.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        evt.scl_level = scl_s;
        evt.sda_level = sda_s;
        evt.scl_rise  = scl_s & ~scl_q;
        evt.scl_fall  = ~scl_s & scl_q;
        // Data moving while the clock stays high is a bus condition.
        evt.start     = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop      = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/twi_store_array.sv
module twi_store_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
    import twi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  bus_evt_t               evt,
    input  logic [STRAP_W-1:0]     strap,
    input  logic [BYTE_W-1:0]      rd_data,
    output logic [WORD_ADDR_W-1:0] ptr,
    output logic                   wr_en,
    output logic [BYTE_W-1:0]      wr_data,
    output logic                   drive_low,
    output twi_state_e             state
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic                 in_ack;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    txreg;
    logic                 master_nack;
    logic                 first_rd;
    logic                 byte_done;

    assign byte_done = evt.scl_fall && !in_ack && (bit_cnt == LAST_BIT);
    assign wr_en     = byte_done && (state == ST_WRITE);
    assign wr_data   = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            in_ack      <= 1'b0;
            shreg       <= '0;
            txreg       <= '0;
            ptr         <= '0;
            drive_low   <= 1'b0;
            master_nack <= 1'b1;
            first_rd    <= 1'b0;
        end else if (evt.stop) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            in_ack    <= 1'b0;
            drive_low <= 1'b0;
            first_rd  <= 1'b0;
        end else if (evt.start) begin
            state     <= ST_SELECT;
            bit_cnt   <= '0;
            in_ack    <= 1'b0;
            drive_low <= 1'b0;
            first_rd  <= 1'b0;
        end else begin
            if (evt.scl_rise) begin
                if (in_ack) begin
                    master_nack <= evt.sda_level;
                end else if (bit_cnt < LAST_BIT) begin
                    shreg   <= {shreg[BYTE_W-2:0], evt.sda_level};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (evt.scl_fall) begin
                if (in_ack) begin
                    // End of the ninth pulse: release, then maybe start a read byte.
                    in_ack    <= 1'b0;
                    bit_cnt   <= '0;
                    drive_low <= 1'b0;
                    if (state == ST_READ) begin
                        if (first_rd || !master_nack) begin
                            drive_low <= ~rd_data[BYTE_W-1];
                            txreg     <= {rd_data[BYTE_W-2:0], 1'b0};
                            ptr       <= ptr + 1'b1;
                            first_rd  <= 1'b0;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end else if (bit_cnt == LAST_BIT) begin
                    in_ack <= 1'b1;
                    unique case (state)
                        ST_SELECT: begin
                            if (select_hit(shreg, strap)) begin
                                drive_low <= 1'b1;
                                first_rd  <= shreg[0];
                                state     <= shreg[0] ? ST_READ : ST_WORD_ADDR;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_WORD_ADDR: begin
                            ptr       <= shreg;
                            drive_low <= 1'b1;
                            state     <= ST_WRITE;
                        end
                        ST_WRITE: begin
                            ptr       <= ptr + 1'b1;
                            drive_low <= 1'b1;
                        end
                        ST_READ: begin
                            drive_low <= 1'b0;
                        end
                        default: begin
                            drive_low <= 1'b0;
                        end
                    endcase
                end else if ((state == ST_READ) && (bit_cnt != '0)) begin
                    drive_low <= ~txreg[BYTE_W-1];
                    txreg     <= {txreg[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/twi_store_slave.sv
module twi_store_slave
    import twi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] dev_strap,
    output logic               sda_drive_low
);

    bus_evt_t               evt;
    logic [WORD_ADDR_W-1:0] ptr;
    logic                   wr_en;
    logic [BYTE_W-1:0]      wr_data;
    logic [BYTE_W-1:0]      rd_data;
    twi_state_e             state;

    twi_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    twi_proto_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .strap     (dev_strap),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .drive_low (sda_drive_low),
        .state     (state)
    );

    twi_store_array #(
        .ADDR_W (WORD_ADDR_W),
        .DATA_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/twi_store_checker.sv
module twi_store_checker
    import twi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_lvl,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       wr_en,
    input logic       drive,
    input twi_state_e state
);

    AST_RESET_RELEASE: assert property (@(posedge clk)
        rst |=> !drive); // R1

    AST_START_TO_SELECT: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (state == ST_SELECT) && !drive); // R2

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !drive); // R4

    AST_WRITE_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(scl_lvl) && !scl_lvl); // R5

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (state == ST_IDLE) && !drive); // R9

    AST_DRIVE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        (drive != $past(drive)) |-> !scl_lvl); // R10

endmodule

bind twi_store_slave twi_store_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (evt.scl_level),
    .start_evt (evt.start),
    .stop_evt  (evt.stop),
    .wr_en     (wr_en),
    .drive     (sda_drive_low),
    .state     (state)
);

// File: tb/twi_store_slave_tb.sv
module twi_store_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       scl   = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       drv;
    logic       sda_bus;

    assign sda_bus = m_sda & ~drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_store_slave u_dut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl),
        .sda_i         (sda_bus),
        .dev_strap     (strap),
        .sda_drive_low (drv)
    );

    int checks = 0;
    int errors = 0;

    // Each entry: {word address, data byte}
    localparam logic [15:0] VEC_TAB [0:7] = '{
        16'h00_3C, 16'h01_C3, 16'h42_5A, 16'h7F_FF,
        16'h80_00, 16'hA5_81, 16'hFF_7E, 16'h10_96
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] sel(input logic [2:0] s, input logic rw);
        return {4'b1010, s, rw};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        scl   = 1'b0; tick(Q);
        m_sda = 1'b0; tick(Q);
        scl   = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(Q);
            scl   = 1'b1; tick(2*Q);
            scl   = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s1;
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        scl   = 1'b1; tick(2);
        s1    = sda_bus; tick(Q);
        acked = !s1 && !sda_bus;
        tick(2*Q - 2 - Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s1;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(2);
            s1  = sda_bus; tick(Q);
            chk(s1 == sda_bus, "R10 data stable in clock high", sda_bus, s1);
            b[i] = sda_bus;
            tick(2*Q - 2 - Q);
            scl = 1'b0;
        end
        tick(Q);
        m_sda = mack; tick(Q);
        scl   = 1'b1; tick(2*Q);
        scl   = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d, input string req);
        logic ak;
        bus_start();
        send_byte(sel(strap, 1'b0), ak); chk(ak, {req, " select ack"}, ak, 1);
        send_byte(a, ak);                chk(ak, {req, " addr ack"}, ak, 1);
        send_byte(d, ak);                chk(ak, {req, " data ack"}, ak, 1);
        bus_stop();
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] d, output logic ok);
        logic ak1, ak2, ak3;
        bus_start();
        send_byte(sel(strap, 1'b0), ak1);
        send_byte(a, ak2);
        bus_start();
        send_byte(sel(strap, 1'b1), ak3);
        recv_byte(1'b1, d);
        bus_stop();
        ok = ak1 && ak2 && ak3;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        logic       ok;
        logic       ak;

        tick(5);
        chk(drv == 1'b0, "R1 released in reset", drv, 0);
        rst = 1'b0;
        tick(2);
        chk(drv == 1'b0, "R1 released after reset", drv, 0);

        // Table of write/read-back vectors (R3 R5 R7)
        for (int k = 0; k < 8; k++) begin
            write_one(VEC_TAB[k][15:8], VEC_TAB[k][7:0], "R5");
        end
        for (int k = 0; k < 8; k++) begin
            read_at(VEC_TAB[k][15:8], rb, ok);
            chk(ok, "R3 read path acks", ok, 1);
            chk(rb == VEC_TAB[k][7:0], "R7 read-back", rb, VEC_TAB[k][7:0]);
        end
        chk(drv == 1'b0, "R8 line free after nack", drv, 0);

        // R6: burst write across the top of the address space
        bus_start();
        send_byte(sel(strap, 1'b0), ak); chk(ak, "R6 select", ak, 1);
        send_byte(8'hFE, ak);            chk(ak, "R6 addr", ak, 1);
        send_byte(8'h11, ak);            chk(ak, "R6 data0", ak, 1);
        send_byte(8'h22, ak);            chk(ak, "R6 data1", ak, 1);
        send_byte(8'h33, ak);            chk(ak, "R6 data2", ak, 1);
        bus_stop();
        // Sequential read from 0xFE with acks (R7, R6)
        bus_start();
        send_byte(sel(strap, 1'b0), ak);
        send_byte(8'hFE, ak);
        bus_start();
        send_byte(sel(strap, 1'b1), ak); chk(ak, "R7 read select", ak, 1);
        recv_byte(1'b0, rb); chk(rb == 8'h11, "R7 seq byte0", rb, 8'h11);
        recv_byte(1'b0, rb); chk(rb == 8'h22, "R6 seq byte1", rb, 8'h22);
        recv_byte(1'b1, rb); chk(rb == 8'h33, "R6 wrapped byte", rb, 8'h33);
        tick(Q);
        chk(drv == 1'b0, "R8 released after nack", drv, 0);
        bus_stop();
        read_at(8'h01, rb, ok);
        chk(rb == 8'hC3, "R6 wrap kept addr 01", rb, 8'hC3);

        // R4: wrong strap, following bytes not acked nor stored
        bus_start();
        send_byte(sel(3'b011, 1'b0), ak); chk(!ak, "R4 wrong strap no ack", ak, 0);
        send_byte(8'h42, ak);             chk(!ak, "R4 addr ignored", ak, 0);
        send_byte(8'hEE, ak);             chk(!ak, "R4 data ignored", ak, 0);
        bus_stop();
        read_at(8'h42, rb, ok);
        chk(rb == 8'h5A, "R4 memory untouched", rb, 8'h5A);

        // R3: wrong family code
        bus_start();
        send_byte({4'b1011, strap, 1'b0}, ak); chk(!ak, "R3 family mismatch", ak, 0);
        bus_stop();

        // R2: repeated START inside a data byte aborts it
        bus_start();
        send_byte(sel(strap, 1'b0), ak);
        send_byte(8'h42, ak);
        send_bits(8'h00, 4);
        bus_start();
        send_byte(sel(strap, 1'b1), ak); chk(ak, "R2 restart select ack", ak, 1);
        recv_byte(1'b1, rb);
        chk(rb == 8'h5A, "R2 partial byte not stored", rb, 8'h5A);
        bus_stop();

        // R9: after STOP, bytes without START are ignored
        tick(Q);
        chk(drv == 1'b0, "R9 idle after stop", drv, 0);
        send_byte(sel(strap, 1'b0), ak); chk(!ak, "R9 no ack without start", ak, 0);
        bus_stop();

        // R11: strap change moves the accepted select byte
        strap = 3'b010;
        tick(Q);
        write_one(8'h20, 8'h77, "R11");
        read_at(8'h20, rb, ok);
        chk(rb == 8'h77, "R11 new strap data", rb, 8'h77);
        bus_start();
        send_byte(sel(3'b101, 1'b0), ak); chk(!ak, "R11 old strap no ack", ak, 0);
        bus_stop();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule